// File: doc/BRIEF.md
# TFT Panel Timing Controller

This block sits between a pixel source and the column and row drivers of a small TFT panel. It takes a pixel clock, horizontal and vertical sync, a data-enable strobe and 18-bit RGB (6 bits per colour). From these it produces the strobes the drivers need. It re-times each accepted pixel onto the column-driver data bus and issues a one-clock start pulse with the first pixel of a line. A one-clock line-latch pulse follows the last pixel. It also drives a row shift clock and a row start pulse, and a polarity signal that alternates line by line and frame by frame.

A static pin selects the geometry. High gives portrait, 240 columns by 320 lines. Low gives landscape, 320 columns by 240 lines. Two direction pins select left/right and up/down scan reversal. The column start pulse leaves on one of two outputs, chosen by the horizontal direction. Each of these outputs carries its own output-enable, and the pad ring turns that enable into the high-impedance state.

Top module: `tft_tcon`

## Requirements
- R1: While `rst_ni` is low at a clock edge, every registered output (`rgb_o`, `src_ctl_o`, both start outputs, `latch_o`, `gate_clk_o`, `gate_start_o`, `pol_o`, `pol_ref_o`) is 0 after that edge, and the pixel, line and frame state is cleared.
- R2: A pixel is accepted on an edge where `de_i` is high, `hsync_i` is low and fewer than W pixels have been accepted since `de_i` was last low or `hsync_i` was last high. W is 240 when `portrait_i` is high and 320 when it is low. Each accepted pixel appears on `rgb_o` ([17:12] red, [11:6] green, [5:0] blue) in the next cycle, with `src_ctl_o` high. In every other cycle `rgb_o` is 0 and `src_ctl_o` is low.
- R3: The start pulse is high for exactly the cycle in which the first accepted pixel of a line is on `rgb_o`. When `hdir_i` is high it appears on `start_l_o`, with `start_l_oe_o`=1 and `start_r_oe_o`=0. When `hdir_i` is low it appears on `start_r_o`, with the enables swapped. A disabled start output drives 0.
- R4: `latch_o` is high for one cycle, the cycle right after the W-th pixel of a line is on `rgb_o`, provided the frame has not reached its line limit (R7). A line with fewer than W accepted pixels gives no latch pulse.
- R5: `gate_clk_o` toggles in exactly the cycles in which `latch_o` rises, and in no others.
- R6: `gate_start_o` takes its new value only together with a latch pulse. It is high from the first latch pulse after a rising edge of `vsync_i` until the next latch pulse.
- R7: The line limit H is 320 lines in portrait and 240 in landscape. After H latch pulses in a frame, further complete lines give no latch pulse, no gate clock toggle and no polarity toggle until `vsync_i` rises again.
- R8: `pol_o` and `pol_ref_o` are always equal. They invert with every latch pulse. On each rising edge of `vsync_i` they are loaded with a frame phase that inverts every frame; the first frame after reset starts at 1.
- R9: When a rising edge of `vsync_i` and a line end fall on the same clock, the latch pulse and gate clock toggle still occur, and `gate_start_o` takes the value armed before that edge. The vertical edge wins for polarity (loaded with the new frame phase) and for the line count (restarted at zero).
- R10: `hflag_o` follows `hdir_i` and `vflag_o` follows `vdir_i` with no delay (1 = normal scan, 0 = reversed).
- R11: `src_clk_o` is the inverse of `clk_i`, so the column driver samples `rgb_o` mid-cycle. `gate_mode_o` follows `portrait_i`.
- R12: A high `hsync_i` while `de_i` is high restarts the pixel count, and no pixel is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync; rising edge starts a frame |
| de_i | input | 1 | Data enable, marks the active part of a line |
| rgb_i | input | 18 | Input pixel, 6 bits per colour |
| hdir_i | input | 1 | Horizontal direction, 1 normal, 0 reversed |
| vdir_i | input | 1 | Vertical direction, 1 normal, 0 reversed |
| portrait_i | input | 1 | Geometry, 1 portrait, 0 landscape |
| src_clk_o | output | 1 | Column-driver shift clock |
| rgb_o | output | 18 | Re-timed pixel data to column drivers |
| src_ctl_o | output | 1 | High while `rgb_o` carries an active pixel |
| start_l_o | output | 1 | Column start pulse, normal-scan side |
| start_l_oe_o | output | 1 | Output enable of `start_l_o` |
| start_r_o | output | 1 | Column start pulse, reversed-scan side |
| start_r_oe_o | output | 1 | Output enable of `start_r_o` |
| latch_o | output | 1 | Line-latch pulse to column drivers |
| gate_clk_o | output | 1 | Row-driver shift clock |
| gate_start_o | output | 1 | Row-driver start pulse |
| gate_mode_o | output | 1 | Row-driver mode, follows geometry |
| pol_o | output | 1 | Polarity reversal for the common electrode |
| pol_ref_o | output | 1 | Polarity reversal for the reference voltage |
| hflag_o | output | 1 | Left/right direction flag |
| vflag_o | output | 1 | Up/down direction flag |

## Verification
A rising edge of vertical sync can fall on the same clock as the end of a line. That single clock then has to latch the line, shift the row clock, and also restart the frame's polarity and line count. The bench provokes this by raising `vsync_i` in the cycle right after the last pixel of a complete line is presented. Its cycle model then expects a latch pulse and a gate clock toggle. It expects polarity to take the new frame phase rather than the toggled value. It expects the row start pulse to appear only on the following line end.

// File: rtl/tcon_pkg.sv
// Shared types for the TFT panel timing controller.
// Assumes 6-bit colour channels packed red, green, blue from MSB down.
package tcon_pkg;
    localparam int COLOR_W = 6;
    localparam int PIX_W   = 3 * COLOR_W;

    typedef struct packed {
        logic [COLOR_W-1:0] red;
        logic [COLOR_W-1:0] green;
        logic [COLOR_W-1:0] blue;
    } pix_t;
endpackage

// File: rtl/tcon_line_timer.sv
// Horizontal timing: counts accepted pixels in a line, re-times them,
// and flags the first and the last pixel of the line.
// Assumes width_i is static during a line and never zero.
module tcon_line_timer
    import tcon_pkg::*;
#(
    parameter int CNT_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             de_i,
    input  logic             hsync_i,
    input  logic [CNT_W-1:0] width_i,
    input  pix_t             pix_i,
    output pix_t             pix_o,
    output logic             act_o,
    output logic             first_o,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             open_line;
    logic             take;

    assign open_line = de_i && !hsync_i;
    assign take      = open_line && (cnt_q < width_i);

    // Pixel counter: restarts whenever the line window closes or sync is seen.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (!open_line) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Output stage: re-timed pixel plus first/last markers aligned with it.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pix_o   <= '0;
            act_o   <= 1'b0;
            first_o <= 1'b0;
            last_o  <= 1'b0;
        end else begin
            pix_o   <= take ? pix_i : '0;
            act_o   <= take;
            first_o <= take && (cnt_q == '0);
            last_o  <= take && (cnt_q == width_i - 1'b1);
        end
    end
endmodule

// File: rtl/tcon_frame_timer.sv
// Vertical timing: line-latch pulse, row shift clock, row start pulse and
// line/frame polarity. A vertical sync edge outranks a line end for the
// polarity and the line count.
// Assumes line_done_i is a single-cycle pulse.
module tcon_frame_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             vsync_i,
    input  logic             line_done_i,
    input  logic [CNT_W-1:0] height_i,
    output logic             latch_o,
    output logic             gate_clk_o,
    output logic             gate_start_o,
    output logic             pol_o
);
    logic             vs_q;
    logic             vs_rise;
    logic             line_end;
    logic             arm_q;
    logic             phase_q;
    logic [CNT_W-1:0] lines_q;

    assign vs_rise  = vsync_i && !vs_q;
    assign line_end = line_done_i && (lines_q < height_i);

    // Sync edge detector and frame phase flip.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            vs_q    <= 1'b0;
            phase_q <= 1'b0;
        end else begin
            vs_q <= vsync_i;
            if (vs_rise) phase_q <= !phase_q;
        end
    end

    // Line counter and row start arming; sync edge has priority.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lines_q <= '0;
            arm_q   <= 1'b0;
        end else if (vs_rise) begin
            lines_q <= '0;
            arm_q   <= 1'b1;
        end else if (line_end) begin
            lines_q <= lines_q + 1'b1;
            arm_q   <= 1'b0;
        end
    end

    // Row-side strobes, all changing on the line end.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            latch_o      <= 1'b0;
            gate_clk_o   <= 1'b0;
            gate_start_o <= 1'b0;
        end else begin
            latch_o <= line_end;
            if (line_end) begin
                gate_clk_o   <= !gate_clk_o;
                gate_start_o <= arm_q;
            end
        end
    end

    // Polarity: loads the new frame phase on sync, else inverts per line.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pol_o <= 1'b0;
        end else if (vs_rise) begin
            pol_o <= !phase_q;
        end else if (line_end) begin
            pol_o <= !pol_o;
        end
    end
endmodule

// File: rtl/tcon_start_router.sv
// Steers the column start pulse to the side chosen by horizontal direction
// and drives the output enables of both sides. Side 0 is the normal-scan
// side. Assumes the pad ring turns a low enable into high impedance.
module tcon_start_router #(
    parameter int SIDES = 2
) (
    input  logic             start_i,
    input  logic             hdir_i,
    output logic [SIDES-1:0] start_o,
    output logic [SIDES-1:0] oe_o
);
    // One enable and one gated pulse per side.
    for (genvar s = 0; s < SIDES; s++) begin : g_side
        if (s == 0) begin : g_normal
            assign oe_o[s] = hdir_i;
        end else begin : g_reverse
            assign oe_o[s] = !hdir_i;
        end
        assign start_o[s] = start_i && oe_o[s];
    end
endmodule

// File: rtl/tft_tcon.sv
// Top of the TFT panel timing controller. Derives the line width and the
// frame height from the geometry pin and ties the line timer, frame timer
// and start router together. Assumes all inputs are synchronous to clk_i
// and that portrait_i is static while running.
module tft_tcon
    import tcon_pkg::*;
#(
    parameter int COLS_PORTRAIT = 240,
    parameter int ROWS_PORTRAIT = 320
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hsync_i,
    input  logic             vsync_i,
    input  logic             de_i,
    input  logic [PIX_W-1:0] rgb_i,
    input  logic             hdir_i,
    input  logic             vdir_i,
    input  logic             portrait_i,
    output logic             src_clk_o,
    output logic [PIX_W-1:0] rgb_o,
    output logic             src_ctl_o,
    output logic             start_l_o,
    output logic             start_l_oe_o,
    output logic             start_r_o,
    output logic             start_r_oe_o,
    output logic             latch_o,
    output logic             gate_clk_o,
    output logic             gate_start_o,
    output logic             gate_mode_o,
    output logic             pol_o,
    output logic             pol_ref_o,
    output logic             hflag_o,
    output logic             vflag_o
);
    localparam int MAX_DIM = (COLS_PORTRAIT > ROWS_PORTRAIT) ? COLS_PORTRAIT : ROWS_PORTRAIT;
    localparam int CNT_W   = $clog2(MAX_DIM + 1);

    logic [CNT_W-1:0] width;
    logic [CNT_W-1:0] height;
    pix_t             pix_in;
    pix_t             pix_out;
    logic             first;
    logic             last;
    logic             pol;
    logic [1:0]       start_side;
    logic [1:0]       oe_side;

    // Geometry selection: landscape swaps the two dimensions.
    assign width  = portrait_i ? CNT_W'(COLS_PORTRAIT) : CNT_W'(ROWS_PORTRAIT);
    assign height = portrait_i ? CNT_W'(ROWS_PORTRAIT) : CNT_W'(COLS_PORTRAIT);
    assign pix_in = pix_t'(rgb_i);

    tcon_line_timer #(.CNT_W(CNT_W)) u_line (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .de_i    (de_i),
        .hsync_i (hsync_i),
        .width_i (width),
        .pix_i   (pix_in),
        .pix_o   (pix_out),
        .act_o   (src_ctl_o),
        .first_o (first),
        .last_o  (last)
    );

    tcon_frame_timer #(.CNT_W(CNT_W)) u_frame (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .vsync_i      (vsync_i),
        .line_done_i  (last),
        .height_i     (height),
        .latch_o      (latch_o),
        .gate_clk_o   (gate_clk_o),
        .gate_start_o (gate_start_o),
        .pol_o        (pol)
    );

    tcon_start_router #(.SIDES(2)) u_route (
        .start_i (first),
        .hdir_i  (hdir_i),
        .start_o (start_side),
        .oe_o    (oe_side)
    );

    // Output wiring and pin-level copies.
    assign rgb_o        = pix_out;
    assign src_clk_o    = !clk_i;
    assign start_l_o    = start_side[0];
    assign start_r_o    = start_side[1];
    assign start_l_oe_o = oe_side[0];
    assign start_r_oe_o = oe_side[1];
    assign pol_o        = pol;
    assign pol_ref_o    = pol;
    assign gate_mode_o  = portrait_i;
    assign hflag_o      = hdir_i;
    assign vflag_o      = vdir_i;
endmodule

// File: rtl/tcon_checker.sv
// Protocol checks on the timing controller's ports, bound to the top.
module tcon_checker (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [17:0] rgb_o,
    input logic        src_ctl_o,
    input logic        start_l_o,
    input logic        start_l_oe_o,
    input logic        start_r_o,
    input logic        start_r_oe_o,
    input logic        latch_o,
    input logic        gate_clk_o,
    input logic        gate_start_o,
    input logic        pol_o,
    input logic        pol_ref_o
);
    p_reset_clears_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (rgb_o == '0 && !latch_o && !gate_clk_o && !gate_start_o && !pol_o));

    p_blank_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !src_ctl_o |-> (rgb_o == '0));

    p_oe_exclusive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_l_oe_o != start_r_oe_o);

    p_start_enabled_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_l_o |-> start_l_oe_o) and (start_r_o |-> start_r_oe_o));

    p_start_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_l_o || start_r_o) |=> !(start_l_o || start_r_o));

    p_latch_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        latch_o |=> !latch_o);

    p_gclk_on_latch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(gate_clk_o) |-> latch_o);

    p_gstart_on_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(gate_start_o) |-> latch_o);

    p_pol_pair_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pol_o == pol_ref_o);
endmodule

bind tft_tcon tcon_checker u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rgb_o        (rgb_o),
    .src_ctl_o    (src_ctl_o),
    .start_l_o    (start_l_o),
    .start_l_oe_o (start_l_oe_o),
    .start_r_o    (start_r_o),
    .start_r_oe_o (start_r_oe_o),
    .latch_o      (latch_o),
    .gate_clk_o   (gate_clk_o),
    .gate_start_o (gate_start_o),
    .pol_o        (pol_o),
    .pol_ref_o    (pol_ref_o)
);

// File: tb/tft_tcon_test.sv
// Cycle model bench for the timing controller, on a reduced geometry.
module tft_tcon_test;
    localparam int PERIOD = 10;
    localparam int CP     = 6;   // portrait columns
    localparam int RP     = 9;   // portrait rows

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        hsync_i = 1'b0, vsync_i = 1'b0, de_i = 1'b0;
    logic [17:0] rgb_i = '0;
    logic        hdir_i = 1'b1, vdir_i = 1'b1, portrait_i = 1'b1;
    logic        src_clk_o, src_ctl_o, start_l_o, start_l_oe_o, start_r_o, start_r_oe_o;
    logic        latch_o, gate_clk_o, gate_start_o, gate_mode_o, pol_o, pol_ref_o;
    logic        hflag_o, vflag_o;
    logic [17:0] rgb_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int          m_cnt = 0, m_lines = 0;
    bit          m_last = 0, m_vsq = 0, m_arm = 0, m_phase = 0;
    logic [17:0] e_rgb = '0;
    bit          e_act = 0, e_start = 0, e_lat = 0, e_gclk = 0, e_gstart = 0, e_pol = 0;
    int          lat_seen = 0;

    always #(PERIOD/2) clk_i = !clk_i;

    tft_tcon #(.COLS_PORTRAIT(CP), .ROWS_PORTRAIT(RP)) uut (.*);

    task automatic chk(input string tag, input logic [17:0] got, input logic [17:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, got, exp);
        end
    endtask

    // Reference model, then compare a quarter period after the edge.
    always @(posedge clk_i) begin
        int  w, h;
        bit  ok, endl, vr, nlast;
        w = portrait_i ? CP : RP;
        h = portrait_i ? RP : CP;
        if (!rst_ni) begin
            m_cnt = 0; m_lines = 0; m_last = 0; m_vsq = 0; m_arm = 0; m_phase = 0;
            e_rgb = '0; e_act = 0; e_start = 0; e_lat = 0; e_gclk = 0; e_gstart = 0; e_pol = 0;
        end else begin
            ok    = de_i && !hsync_i && (m_cnt < w);
            endl  = m_last && (m_lines < h);
            vr    = vsync_i && !m_vsq;
            nlast = ok && (m_cnt == w - 1);
            e_rgb   = ok ? rgb_i : '0;
            e_act   = ok;
            e_start = ok && (m_cnt == 0);
            if (de_i && !hsync_i) m_cnt = m_cnt + (ok ? 1 : 0); else m_cnt = 0;
            e_lat = endl;
            if (endl) begin
                e_gclk   = !e_gclk;
                e_gstart = m_arm;
                lat_seen++;
            end
            if (vr) begin m_arm = 1; m_lines = 0; end
            else if (endl) begin m_arm = 0; m_lines++; end
            if (vr) begin m_phase = !m_phase; e_pol = m_phase; end
            else if (endl) e_pol = !e_pol;
            m_last = nlast;
            m_vsq  = vsync_i;
        end
        #(PERIOD/4);
        chk("R2 R12 rgb", rgb_o, e_rgb);
        chk("R2 src_ctl", 18'(src_ctl_o), 18'(e_act));
        chk("R3 start_l", 18'(start_l_o), 18'(e_start && hdir_i));
        chk("R3 start_r", 18'(start_r_o), 18'(e_start && !hdir_i));
        chk("R3 oe_l", 18'(start_l_oe_o), 18'(hdir_i));
        chk("R3 oe_r", 18'(start_r_oe_o), 18'(!hdir_i));
        chk("R4 R7 R9 latch", 18'(latch_o), 18'(e_lat));
        chk("R5 R7 gate_clk", 18'(gate_clk_o), 18'(e_gclk));
        chk("R6 R9 gate_start", 18'(gate_start_o), 18'(e_gstart));
        chk("R8 R9 pol", 18'(pol_o), 18'(e_pol));
        chk("R8 pol_ref", 18'(pol_ref_o), 18'(e_pol));
        chk("R10 hflag", 18'(hflag_o), 18'(hdir_i));
        chk("R10 vflag", 18'(vflag_o), 18'(vdir_i));
        chk("R11 src_clk", 18'(src_clk_o), 18'(!clk_i));
        chk("R11 gate_mode", 18'(gate_mode_o), 18'(portrait_i));
    end

    task automatic run_line(input int n, input bit vs_coincide);
        @(negedge clk_i); hsync_i = 1'b1;
        @(negedge clk_i); hsync_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk_i); de_i = 1'b1; rgb_i = 18'($urandom);
        end
        @(negedge clk_i); de_i = 1'b0; rgb_i = '0; vsync_i = vs_coincide;
        repeat (3) @(negedge clk_i);
        vsync_i = 1'b0;
    endtask

    task automatic start_frame();
        @(negedge clk_i); vsync_i = 1'b1;
        repeat (2) @(negedge clk_i);
        vsync_i = 1'b0;
    endtask

    task automatic run_frame(input int lines);
        int w;
        w = portrait_i ? CP : RP;
        start_frame();
        for (int l = 0; l < lines; l++) run_line(w, 1'b0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        // R1: registered outputs cleared by reset
        checks++;
        if (rgb_o !== '0 || latch_o !== 1'b0 || pol_o !== 1'b0 || gate_start_o !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs: rgb %0h lat %b pol %b gs %b expected all 0",
                     rgb_o, latch_o, pol_o, gate_start_o);
        end
        rst_ni = 1'b1;
        // portrait, normal scan, two lines past the limit (R7)
        run_frame(RP + 2);
        checks++;
        if (lat_seen != RP) begin
            errors++;
            $display("FAIL R7 latch count: got %0d expected %0d", lat_seen, RP);
        end
        // reversed scan, short and long lines
        hdir_i = 1'b0; vdir_i = 1'b0;
        start_frame();
        run_line(CP, 1'b0);
        run_line(3, 1'b0);
        run_line(CP + 3, 1'b0);
        run_line(CP, 1'b0);
        // landscape geometry
        portrait_i = 1'b0; hdir_i = 1'b1;
        run_frame(CP + 2);
        // sync edge on the same clock as a line end (R9)
        start_frame();
        run_line(RP, 1'b0);
        run_line(RP, 1'b1);
        run_line(RP, 1'b0);
        run_line(RP, 1'b0);
        // R12: sync inside an active line restarts the count
        portrait_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk_i); de_i = 1'b1; rgb_i = 18'($urandom);
        end
        @(negedge clk_i); hsync_i = 1'b1;
        @(negedge clk_i); hsync_i = 1'b0;
        for (int i = 0; i < CP; i++) begin
            @(negedge clk_i); de_i = 1'b1; rgb_i = 18'($urandom);
        end
        @(negedge clk_i); de_i = 1'b0;
        repeat (3) @(negedge clk_i);
        // reset in mid-frame, then a fresh frame
        run_line(CP, 1'b0);
        @(negedge clk_i); rst_ni = 1'b0;
        repeat (2) @(negedge clk_i);
        rst_ni = 1'b1;
        run_frame(4);
        repeat (4) @(negedge clk_i);
        done = 1;
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            finish_run();
        end
    end
endmodule